// File: doc/BRIEF.md
# Wired-AND Barrier Synchronizer

This controller lets one module join a barrier rendezvous with its peers over a single shared open-drain control line. The line has a weak pull-up, and any participant can force it low. After reset every controller holds the line low. When its local module reports it is ready, the controller lets go of the line and then only watches it. The line can rise only after the last participant has let go. When the controller senses the line high, it gives its module a one-cycle start pulse. When the module reports that its operation is finished, the controller pulls the line low again. It waits until it senses the line low before it accepts a new ready request.

The sense input carries the resolved level of the line, not the controller's own drive. It passes through a synchronizer before the state machine uses it. The pull-down output is active-low: a 0 means the controller is pulling the line low, and a 1 means it has released the line. The line itself is built outside the block by combining every participant's output in a wired-AND.

Top module: `wand_barrier_ctrl`

## Requirements
- R1: While reset is active and after it is released, pull_en_no is 0 (pulling low) and proceed_o is 0 until ready_i is seen.
- R2: When ready_i is 1 in the holding state, pull_en_no becomes 1 after the next clock edge. It stays 1 until done_i is accepted in the running state.
- R3: line_i passes through SYNC_STAGES flops (default 2) before the state machine uses it. With the default, proceed_o is high in the cycle that follows the third rising edge after line_i first reads 1 while the controller is released.
- R4: proceed_o pulses for exactly one cycle, and only after the synchronized line reads 1. No participant's proceed_o pulses while any participant still holds the line low.
- R5: done_i asserted while the controller waits for the line to rise is ignored: pull_en_no stays 1 and the proceed pulse still occurs.
- R6: When done_i is 1 in the running state, pull_en_no returns to 0 after the next clock edge.
- R7: After re-asserting the pull-down, the controller keeps pull_en_no at 0 and ignores ready_i until the synchronized line reads 0. With ready_i held at 1, pull_en_no returns to 1 after the fourth edge that follows the edge accepting done_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 1 | Local module is ready to rendezvous |
| done_i | input | 1 | Local module has finished its operation |
| line_i | input | 1 | Resolved level of the shared line (asynchronous) |
| pull_en_no | output | 1 | Pull-down enable, active low (0 = hold line low) |
| proceed_o | output | 1 | One-cycle start pulse to the local module |

## Verification
The release is due one edge after ready_i is sampled, and the re-assertion is due one edge after done_i is accepted. The proceed pulse is due four edges after the edge that samples the last participant's ready_i: one edge to release, two synchronizer edges, and one edge for the state change. The re-release after done_i, with ready_i held high, is due four edges after done_i. In that case the next proceed pulse follows three edges later. The driver computes each due cycle from a free-running cycle counter and pushes it into a per-participant queue. The monitor samples at the falling edge, pops the queue on every pulse and compares the cycle numbers. A pulse that arrives with an empty queue is reported as a premature start.

// File: rtl/wand_barrier_pkg.sv
package wand_barrier_pkg;
  typedef enum logic [1:0] {
    ST_IDLE_HOLD,
    ST_RELEASED_WAIT,
    ST_RUNNING,
    ST_REASSERT_WAIT
  } bar_state_e;
endpackage

// File: rtl/wand_line_sync.sv
module wand_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] sreg_q;

  // line is held low by this participant in reset, so clear to 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sreg_q <= '0;
    else         sreg_q <= {sreg_q[LAST-1:0], d_i};
  end

  assign q_o = sreg_q[LAST];

  assert_sync_one_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sreg_q[0] == $past(d_i) || $past(!rst_ni));
endmodule

// File: rtl/wand_barrier_fsm.sv
module wand_barrier_fsm
  import wand_barrier_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  input  logic done_i,
  input  logic sense_i,
  output logic pull_en_no,
  output logic proceed_o
);
  bar_state_e state_q, state_d;
  logic       proceed_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE_HOLD:     if (ready_i) state_d = ST_RELEASED_WAIT;
      ST_RELEASED_WAIT: if (sense_i) state_d = ST_RUNNING;        // done_i ignored here
      ST_RUNNING:       if (done_i)  state_d = ST_REASSERT_WAIT;
      ST_REASSERT_WAIT: if (!sense_i) state_d = ST_IDLE_HOLD;
      default:          state_d = ST_IDLE_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE_HOLD;
      proceed_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      proceed_q <= (state_q == ST_RELEASED_WAIT) && sense_i;
    end
  end

  assign pull_en_no = (state_q == ST_RELEASED_WAIT) || (state_q == ST_RUNNING);
  assign proceed_o  = proceed_q;

  assert_release_on_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE_HOLD && ready_i) |=> pull_en_no);

  assert_proceed_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proceed_o |=> !proceed_o);

  assert_proceed_needs_line_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(proceed_o) |-> $past(sense_i));

  assert_early_done_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RELEASED_WAIT && !sense_i && done_i) |=> pull_en_no);

  assert_reassert_on_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUNNING && done_i) |=> !pull_en_no);

  assert_hold_until_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REASSERT_WAIT && sense_i) |=> !pull_en_no);
endmodule

// File: rtl/wand_barrier_ctrl.sv
module wand_barrier_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  input  logic done_i,
  input  logic line_i,
  output logic pull_en_no,
  output logic proceed_o
);
  logic sense_s;

  wand_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (line_i),
    .q_o    (sense_s)
  );

  wand_barrier_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ready_i    (ready_i),
    .done_i     (done_i),
    .sense_i    (sense_s),
    .pull_en_no (pull_en_no),
    .proceed_o  (proceed_o)
  );

  assert_reset_holds_line_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!pull_en_no && !proceed_o));
endmodule

// File: tb/sim_wand_barrier_ctrl.sv
module sim_wand_barrier_ctrl;
  localparam int NP = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] ready = '0;
  logic [NP-1:0] done = '0;
  logic [NP-1:0] pull_n;
  logic [NP-1:0] proceed;
  logic          line;
  int            cyc = 0;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            finished = 1'b0;
  int            exp_q [NP][$];

  always #4ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // wired-AND with weak pull-up: high only when every participant releases
  assign line = &pull_n;

  for (genvar g = 0; g < NP; g++) begin : gen_p
    wand_barrier_ctrl u0 (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .ready_i    (ready[g]),
      .done_i     (done[g]),
      .line_i     (line),
      .pull_en_no (pull_n[g]),
      .proceed_o  (proceed[g])
    );
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic expect_proceed(input int c);
    for (int i = 0; i < NP; i++) exp_q[i].push_back(c);
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // monitor: each pulse must match a queued due cycle
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NP; i++) begin
        if (proceed[i]) begin
          if (exp_q[i].size() == 0) begin
            chk(1'b0, "R4 premature proceed", 1, 0);
          end else begin
            int e;
            e = exp_q[i].pop_front();
            chk(cyc == e, "R3 proceed cycle", cyc, e);
          end
        end
      end
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8ns * 100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    chk(pull_n == '0, "R1 reset pull", pull_n, 0);
    chk(proceed == '0, "R1 reset proceed", proceed, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(pull_n == '0, "R1 idle after reset", pull_n, 0);

    // round A: staggered ready, early done on participant 0
    ready[0] = 1'b1;
    @(negedge clk);
    chk(pull_n[0] == 1'b1, "R2 release", pull_n[0], 1);
    chk(line == 1'b0, "R4 line held by peers", line, 0);
    done[0] = 1'b1;
    repeat (4) @(negedge clk);
    ready[1] = 1'b1;
    @(negedge clk);
    chk(pull_n[0] == 1'b1, "R5 early done ignored", pull_n[0], 1);
    chk(pull_n[1] == 1'b1, "R2 release p1", pull_n[1], 1);
    chk(line == 1'b0, "R4 line held by p2", line, 0);
    repeat (3) @(negedge clk);
    chk(pull_n[0] == 1'b1, "R5 still released", pull_n[0], 1);
    ready[2] = 1'b1;
    c = cyc;
    expect_proceed(c + 4);
    wait_to(c + 5);
    chk(pull_n[0] == 1'b0, "R6 reassert p0", pull_n[0], 0);
    chk(pull_n[1] == 1'b1, "R6 p1 still running", pull_n[1], 1);
    ready = '0;
    done  = 3'b110;
    @(negedge clk);
    done = '0;
    chk(pull_n == '0, "R6 reassert all", pull_n, 0);
    repeat (6) @(negedge clk);
    chk(pull_n == '0, "R7 back to idle hold", pull_n, 0);

    // round B: simultaneous ready, then re-release with ready held
    ready = '1;
    c = cyc;
    expect_proceed(c + 4);
    wait_to(c + 6);
    done = '1;
    c = cyc;
    expect_proceed(c + 8);
    @(negedge clk);
    done = '0;
    chk(pull_n == '0, "R6 reassert on done", pull_n, 0);
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk);
      chk(pull_n == '0, "R7 hold until sensed low", pull_n, 0);
    end
    @(negedge clk);
    chk(pull_n == '1, "R7 re-release", pull_n, 7);
    wait_to(c + 10);
    ready = '0;
    done  = '1;
    @(negedge clk);
    done = '0;
    repeat (6) @(negedge clk);
    chk(pull_n == '0, "R1 idle hold", pull_n, 0);

    // round C: reversed order
    ready[2] = 1'b1;
    repeat (2) @(negedge clk);
    ready[1] = 1'b1;
    repeat (3) @(negedge clk);
    chk(line == 1'b0, "R4 line held by p0", line, 0);
    chk(proceed == '0, "R4 no start yet", proceed, 0);
    ready[0] = 1'b1;
    c = cyc;
    expect_proceed(c + 4);
    wait_to(c + 8);

    for (int i = 0; i < NP; i++)
      chk(exp_q[i].size() == 0, "R4 missing proceed", exp_q[i].size(), 0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule